// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block forms the single trigger line that a master timer hands to its slave timers. A mode field picks one of several internal timer signals and routes it to the line. Some of these signals are one-cycle event strobes: a software-requested update, the update event, and the channel-1 capture/compare event. Others are levels: the counter enable and the four output-compare reference signals.

The counter enable source is the OR of the software enable bit and an enable that comes from the trigger input in gated mode. The gated path passes through an extra register stage, so an enable driven by the trigger input reaches the line one cycle later than the software bit does. The trigger line is taken from a register, so every source appears on it one clock after its cause. A change of mode therefore takes effect at a clock edge, and no combinational glitch can reach slave timers.

Top module: `tmr_trig_out_sel`

## Requirements
- R1: While `rst_n` is low, `trig_out` is 0.
- R2: With mode code 0, `trig_out` in cycle t+1 equals `sw_upd_strobe` sampled in cycle t.
- R3: With mode code 2, `trig_out` in cycle t+1 equals `upd_evt` sampled in cycle t.
- R4: With mode code 3, each cycle in which `cc1_evt` is high gives a high `trig_out` one cycle later. This holds for events on back-to-back cycles, with no suppression because an earlier event is still pending.
- R5: With mode code 4+i (i = 0..3), `trig_out` in cycle t+1 equals `oc_ref[i]` sampled in cycle t.
- R6: With mode code 1, a high `cen_bit` in cycle t makes `trig_out` high in cycle t+1.
- R7: With mode code 1, `gate_en` passes through one extra register stage. `trig_out` in cycle t+1 is `cen_bit`(t) OR `gate_en`(t-1).
- R8: After a mode change at an edge, `trig_out` reflects only the newly selected source. The sources of other modes have no effect on it.
- R9: In the event modes (codes 0, 2, 3), a single-cycle input event gives `trig_out` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | MODE_W (3) | Source select code |
| sw_upd_strobe | input | 1 | Software update-generation strobe |
| cen_bit | input | 1 | Software counter enable bit |
| gate_en | input | 1 | Counter enable from trigger input in gated mode |
| upd_evt | input | 1 | Update event strobe |
| cc1_evt | input | 1 | Channel-1 capture/compare event strobe |
| oc_ref | input | NUM_REF (4) | Output-compare reference levels |
| trig_out | output | 1 | Registered trigger output |

## Verification
The bench builds the block with its defaults: four reference inputs, a 3-bit mode field and one gated-enable stage. With these values every one of the eight mode codes is a valid selection, so random mode changes reach every source and every switch between two sources. The single gate stage gives the enable mode a two-cycle path next to the one-cycle software path, and the bench covers both paths when they overlap and when they do not.

// File: rtl/trgo_pkg.sv
package trgo_pkg;
  // First mode code that selects a compare reference level
  localparam int unsigned REF_BASE = 4;

  typedef enum logic [1:0] {
    SRC_SWUPD   = 2'd0,
    SRC_ENABLE  = 2'd1,
    SRC_UPDATE  = 2'd2,
    SRC_CCPULSE = 2'd3
  } evt_src_e;
endpackage

// File: rtl/trgo_enable_merge.sv
module trgo_enable_merge #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cen,
  input  logic gate_en,
  output logic cnt_en
);
  logic [STAGES-1:0] gate_q;
  logic [STAGES-1:0] gate_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb gate_d = gate_en;
    end else begin : g_many
      always_comb gate_d = {gate_q[STAGES-2:0], gate_en};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_d;
  end

  // Software bit is immediate; the gated path lags by STAGES cycles
  assign cnt_en = cen | gate_q[STAGES-1];
endmodule

// File: rtl/trgo_source_mux.sv
module trgo_source_mux
  import trgo_pkg::*;
#(
  parameter int unsigned NUM_REF = 4,
  parameter int unsigned MODE_W  = 3
) (
  input  logic [MODE_W-1:0]  mode_sel,
  input  logic               sw_upd,
  input  logic               cnt_en,
  input  logic               upd_evt,
  input  logic               cc1_evt,
  input  logic [NUM_REF-1:0] oc_ref,
  output logic               sel_out
);
  logic [NUM_REF-1:0] ref_hit;
  logic               evt_sel;
  evt_src_e           src;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REF; gi++) begin : g_ref
      assign ref_hit[gi] = (mode_sel == MODE_W'(REF_BASE + gi)) & oc_ref[gi];
    end
  endgenerate

  assign src = evt_src_e'(mode_sel[1:0]);

  always_comb begin
    unique case (src)
      SRC_SWUPD:   evt_sel = sw_upd;
      SRC_ENABLE:  evt_sel = cnt_en;
      SRC_UPDATE:  evt_sel = upd_evt;
      SRC_CCPULSE: evt_sel = cc1_evt;
      default:     evt_sel = 1'b0;
    endcase
  end

  always_comb begin
    if (mode_sel < MODE_W'(REF_BASE)) sel_out = evt_sel;
    else                              sel_out = |ref_hit;
  end
endmodule

// File: rtl/tmr_trig_out_sel.sv
module tmr_trig_out_sel #(
  parameter int unsigned NUM_REF     = 4,
  parameter int unsigned GATE_STAGES = 1,
  localparam int unsigned MODE_W     = $clog2(trgo_pkg::REF_BASE + NUM_REF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODE_W-1:0]  mode_sel,
  input  logic               sw_upd_strobe,
  input  logic               cen_bit,
  input  logic               gate_en,
  input  logic               upd_evt,
  input  logic               cc1_evt,
  input  logic [NUM_REF-1:0] oc_ref,
  output logic               trig_out
);
  logic cnt_en;
  logic trig_d;
  logic trig_q;

  trgo_enable_merge #(.STAGES(GATE_STAGES)) en_merge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cen     (cen_bit),
    .gate_en (gate_en),
    .cnt_en  (cnt_en)
  );

  trgo_source_mux #(.NUM_REF(NUM_REF), .MODE_W(MODE_W)) src_mux_i (
    .mode_sel (mode_sel),
    .sw_upd   (sw_upd_strobe),
    .cnt_en   (cnt_en),
    .upd_evt  (upd_evt),
    .cc1_evt  (cc1_evt),
    .oc_ref   (oc_ref),
    .sel_out  (trig_d)
  );

  // Output register: glitch-free line toward slave timers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_d;
  end

  assign trig_out = trig_q;
endmodule

// File: rtl/trgo_checker.sv
module trgo_checker #(
  parameter int unsigned NUM_REF = 4,
  parameter int unsigned MODE_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [MODE_W-1:0]  mode_sel,
  input logic               sw_upd_strobe,
  input logic               cen_bit,
  input logic               upd_evt,
  input logic               cc1_evt,
  input logic [NUM_REF-1:0] oc_ref,
  input logic               trig_out
);
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> !trig_out);

  a_r2_sw_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_W'(0)) |=> (trig_out == $past(sw_upd_strobe)));

  a_r3_update: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_W'(2)) |=> (trig_out == $past(upd_evt)));

  a_r4_cc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_W'(3) && cc1_evt) |=> trig_out);

  a_r6_sw_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_W'(1) && cen_bit) |=> trig_out);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REF; gi++) begin : g_chk
      a_r5_ref_level: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_W'(4 + gi)) |=> (trig_out == $past(oc_ref[gi])));
    end
  endgenerate
endmodule

bind tmr_trig_out_sel trgo_checker #(.NUM_REF(NUM_REF), .MODE_W(MODE_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_sel      (mode_sel),
  .sw_upd_strobe (sw_upd_strobe),
  .cen_bit       (cen_bit),
  .upd_evt       (upd_evt),
  .cc1_evt       (cc1_evt),
  .oc_ref        (oc_ref),
  .trig_out      (trig_out)
);

// File: tb/tmr_trig_out_sel_tb_top.sv
module tmr_trig_out_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_sel;
  logic       sw_upd_strobe, cen_bit, gate_en, upd_evt, cc1_evt;
  logic [3:0] oc_ref;
  logic       trig_out;

  int checks = 0;
  int fails  = 0;
  logic gate_old = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_trig_out_sel dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .sw_upd_strobe(sw_upd_strobe), .cen_bit(cen_bit), .gate_en(gate_en),
    .upd_evt(upd_evt), .cc1_evt(cc1_evt), .oc_ref(oc_ref), .trig_out(trig_out)
  );

  function automatic logic model(input logic [2:0] m, input logic sw, input logic cen,
                                 input logic gold, input logic up, input logic cc,
                                 input logic [3:0] r);
    case (m)
      3'd0: return sw;
      3'd1: return cen | gold;
      3'd2: return up;
      3'd3: return cc;
      default: return r[m - 3'd4];
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m, input logic cen);
    case (m)
      3'd0: return "R2";
      3'd1: return cen ? "R6" : "R7";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: trig_out=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Drive inputs at negedge, let one posedge register them, check at next negedge
  task automatic step(input logic [2:0] m, input logic sw, input logic cen, input logic g,
                      input logic up, input logic cc, input logic [3:0] r, input string tag);
    logic e;
    string t;
    mode_sel = m; sw_upd_strobe = sw; cen_bit = cen; gate_en = g;
    upd_evt = up; cc1_evt = cc; oc_ref = r;
    @(posedge clk);
    @(negedge clk);
    e = model(m, sw, cen, gate_old, up, cc, r);
    t = (tag == "") ? req_of(m, cen) : tag;
    check(t, trig_out, e);
    gate_old = g;
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = 3'd0; sw_upd_strobe = 0; cen_bit = 0; gate_en = 0;
    upd_evt = 0; cc1_evt = 0; oc_ref = 4'h0;
    void'($urandom(32'h1d5eed));
    // R1: reset holds the line low even with sources active
    mode_sel = 3'd4; oc_ref = 4'hF;
    repeat (3) @(negedge clk);
    check("R1", trig_out, 1'b0);
    oc_ref = 4'h0; mode_sel = 3'd0;
    @(negedge clk);
    check("R1", trig_out, 1'b0);
    rst_n = 1'b1;

    // R4: back-to-back channel-1 events each give a pulse
    repeat (3) step(3'd3, 0, 0, 0, 0, 1, 4'h0, "R4");
    step(3'd3, 0, 0, 0, 0, 0, 4'h0, "R4");
    // R9: single-cycle update event -> exactly one high cycle
    step(3'd2, 0, 0, 0, 1, 0, 4'h0, "R9");
    step(3'd2, 0, 0, 0, 0, 0, 4'h0, "R9");
    step(3'd0, 1, 0, 0, 0, 0, 4'h0, "R9");
    step(3'd0, 0, 0, 0, 0, 0, 4'h0, "R9");
    // R7: gated enable arrives one cycle later than the software bit
    step(3'd1, 0, 0, 1, 0, 0, 4'h0, "R7");
    step(3'd1, 0, 0, 0, 0, 0, 4'h0, "R7");
    step(3'd1, 0, 0, 0, 0, 0, 4'h0, "R7");
    step(3'd1, 0, 1, 0, 0, 0, 4'h0, "R6");
    // R8: leaving a high reference mode, the old source no longer counts
    step(3'd4, 0, 0, 0, 0, 0, 4'h1, "R5");
    step(3'd0, 0, 1, 1, 1, 1, 4'hF, "R8");
    step(3'd7, 1, 1, 0, 1, 1, 4'h7, "R8");
    step(3'd6, 0, 0, 0, 0, 0, 4'h4, "R5");

    // Random stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      step(m, ($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
           4'($urandom), "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule